// File: doc/BRIEF.md
# Base-Mask Priority Address Decoder

This block classifies each bus cycle by its address. Eight programmable regions, each with a base, a mask and a valid bit, are compared in parallel against the upper half of the cycle address. The regions fall into five classes: two on-chip RAM regions, a lower-priority and a higher-priority system-bus-controller region, two chip-select regions and two DRAM regions. A fixed priority across these classes turns the set of hits into one access kind and the index of the region that won. When no region hits, or when the hits form a combination with no defined meaning, the block raises an error.

Software loads one region at a time through a simple write port. A start strobe marks a new cycle. One clock later the result is registered, and it holds until the next strobe. The downstream bus engine reads the one-hot kind to choose between the on-chip RAM path, a bus-controller path, the external chip-select sequencer or the DRAM controller. It reads the index to fetch that region's control settings.

Top module: `addr_region_decoder`

## Requirements
- R1: A valid region hits when, for every address bit 31..16 whose mask bit is 0, the address bit equals the base bit. Mask bit 1 makes that bit don't-care. Address bits 15..0 never affect the result.
- R2: A region whose valid bit is 0 never hits, whatever its base and mask.
- R3: A hit on region 0 or 1 (on-chip RAM) gives kind RAM whatever else hits. The index is the lowest RAM region that hits.
- R4: With no RAM hit, a hit on region 3 (high-priority bus controller) gives kind BUS2 with index 3, whatever else hits.
- R5: With no RAM and no region-3 hit, a hit on region 2 (low-priority bus controller) gives kind BUS1 with index 2, but only when neither region 4 nor region 5 hits. DRAM hits do not prevent it.
- R6: With no hit on regions 0..3, exactly one hit among regions 4..5 (chip selects) and no hit on regions 6..7 gives kind CHIPSEL, with the index of that region.
- R7: With no hit on regions 0..3, exactly one hit among regions 6..7 (DRAM) and no chip-select hit gives kind DRAM, with the index of that region.
- R8: A cycle that hits no region sets the error flag.
- R9: Every other combination sets the error flag. This covers two chip-select hits, two DRAM hits, a chip-select hit together with a DRAM hit, and a region-2 hit together with a chip-select hit.
- R10: The kind output is one-hot: bit 0 RAM, bit 1 BUS2, bit 2 BUS1, bit 3 CHIPSEL, bit 4 DRAM. When the error flag is set, kind and index are all zero.
- R11: The result appears on the outputs at the clock edge that samples the start strobe. It stays unchanged while start is low, even if the address or the configuration changes.
- R12: Reset clears the outputs to zero and clears every region's valid bit, base and mask.
- R13: A write with cfg_we high loads the valid bit, base and mask of the region chosen by cfg_idx. Other regions keep their settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region configuration write enable |
| cfg_idx | input | 3 | Region selected for the write |
| cfg_valid | input | 1 | Valid bit to load |
| cfg_base | input | 16 | Base for address bits 31..16 |
| cfg_mask | input | 16 | Don't-care mask for address bits 31..16 |
| start | input | 1 | New bus cycle strobe |
| addr | input | 32 | Bus cycle address |
| acc_kind | output | 5 | One-hot access kind |
| region_idx | output | 3 | Index of the winning region |
| dec_err | output | 1 | Decode error flag |

## Verification
The cases that are hardest to reach are those where hits overlap, because several regions must be programmed to cover the same address at once. The bench builds one fixed map in which the RAM regions overlap the high-priority controller, and the low-priority controller overlaps both a chip-select window and a DRAM window. A single address sweep then covers every priority step and every masked boundary. Directed reprogramming follows. It produces the chip-select plus DRAM case, the double chip-select case and the double DRAM case, and it clears one valid bit to show that the overlap it caused disappears.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    localparam int ADDR_W   = 32;
    localparam int CMP_HI   = 31;
    localparam int CMP_LO   = 16;
    localparam int CMP_W    = CMP_HI - CMP_LO + 1;
    localparam int N_REGION = 8;
    localparam int IDX_W    = $clog2(N_REGION);
    localparam int N_KIND   = 5;

    // region slots; the resolver priority depends on this placement
    localparam int SLOT_RAM0 = 0;
    localparam int SLOT_RAM1 = 1;
    localparam int SLOT_BUS1 = 2;
    localparam int SLOT_BUS2 = 3;
    localparam int SLOT_CS0  = 4;
    localparam int SLOT_CS1  = 5;
    localparam int SLOT_DR0  = 6;
    localparam int SLOT_DR1  = 7;

    typedef struct packed {
        logic             valid;
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
    } region_cfg_t;

    typedef enum logic [N_KIND-1:0] {
        KIND_NONE    = 5'b00000,
        KIND_RAM     = 5'b00001,
        KIND_BUS2    = 5'b00010,
        KIND_BUS1    = 5'b00100,
        KIND_CHIPSEL = 5'b01000,
        KIND_DRAM    = 5'b10000
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
        logic             err;
    } decode_t;

    localparam decode_t DECODE_IDLE = '{kind: KIND_NONE, idx: '0, err: 1'b0};

    // a bit position is compared only where the mask bit is 0
    function automatic logic region_hit(region_cfg_t cfg, logic [CMP_W-1:0] a_hi);
        return cfg.valid && (((a_hi ^ cfg.base) & ~cfg.mask) == '0);
    endfunction

    // pick the lower slot of a two-slot class
    function automatic logic [IDX_W-1:0] pair_pick(logic [1:0] h, int first_slot);
        return h[0] ? IDX_W'(first_slot) : IDX_W'(first_slot + 1);
    endfunction

endpackage

// File: rtl/region_cfg_bank.sv
module region_cfg_bank
    import addr_dec_pkg::*;
#(
    parameter int NREG = N_REGION,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IW-1:0]                wr_idx,
    input  region_cfg_t                  wr_cfg,
    output region_cfg_t [NREG-1:0]       cfg_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                cfg_q[g] <= wr_cfg;
            end
        end
    end

endmodule

// File: rtl/region_match_array.sv
module region_match_array
    import addr_dec_pkg::*;
#(
    parameter int NREG = N_REGION,
    parameter int CW   = CMP_W
) (
    input  region_cfg_t [NREG-1:0] cfg,
    input  logic [CW-1:0]          a_hi,
    output logic [NREG-1:0]        hit
);

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit[g] = region_hit(cfg[g], a_hi);
    end

endmodule

// File: rtl/class_resolver.sv
module class_resolver
    import addr_dec_pkg::*;
(
    input  logic [N_REGION-1:0] hit,
    output decode_t             res
);

    logic [1:0] ram_h, cs_h, dr_h;
    logic       bus1_h, bus2_h;

    assign ram_h  = {hit[SLOT_RAM1], hit[SLOT_RAM0]};
    assign cs_h   = {hit[SLOT_CS1],  hit[SLOT_CS0]};
    assign dr_h   = {hit[SLOT_DR1],  hit[SLOT_DR0]};
    assign bus1_h = hit[SLOT_BUS1];
    assign bus2_h = hit[SLOT_BUS2];

    always_comb begin
        res = DECODE_IDLE;
        if (|ram_h) begin
            res.kind = KIND_RAM;
            res.idx  = pair_pick(ram_h, SLOT_RAM0);
        end else if (bus2_h) begin
            res.kind = KIND_BUS2;
            res.idx  = IDX_W'(SLOT_BUS2);
        end else if (bus1_h && !(|cs_h)) begin
            res.kind = KIND_BUS1;
            res.idx  = IDX_W'(SLOT_BUS1);
        end else if (!bus1_h && (^cs_h) && !(|dr_h)) begin
            res.kind = KIND_CHIPSEL;
            res.idx  = pair_pick(cs_h, SLOT_CS0);
        end else if (!bus1_h && !(|cs_h) && (^dr_h)) begin
            res.kind = KIND_DRAM;
            res.idx  = pair_pick(dr_h, SLOT_DR0);
        end else begin
            res.err  = 1'b1;
        end
    end

endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
    import addr_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [CMP_W-1:0]  cfg_base,
    input  logic [CMP_W-1:0]  cfg_mask,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_KIND-1:0] acc_kind,
    output logic [IDX_W-1:0]  region_idx,
    output logic              dec_err
);

    region_cfg_t [N_REGION-1:0] cfg_q;
    region_cfg_t                wr_cfg;
    logic [N_REGION-1:0]        hit;
    decode_t                    res_d, res_q;
    logic                       unused_lo;

    assign wr_cfg    = '{valid: cfg_valid, base: cfg_base, mask: cfg_mask};
    assign unused_lo = ^addr[CMP_LO-1:0];

    region_cfg_bank #(.NREG(N_REGION)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_cfg (wr_cfg),
        .cfg_q  (cfg_q)
    );

    region_match_array #(.NREG(N_REGION), .CW(CMP_W)) u_match (
        .cfg  (cfg_q),
        .a_hi (addr[CMP_HI:CMP_LO]),
        .hit  (hit)
    );

    class_resolver u_resolve (
        .hit (hit),
        .res (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= DECODE_IDLE;
        end else if (start) begin
            res_q <= res_d;
        end
    end

    assign acc_kind   = res_q.kind;
    assign region_idx = res_q.idx;
    assign dec_err    = res_q.err;

endmodule

// File: rtl/addr_region_decoder_chk.sv
module addr_region_decoder_chk
    import addr_dec_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [N_REGION-1:0] hit,
    input logic [N_KIND-1:0]   acc_kind,
    input logic [IDX_W-1:0]    region_idx,
    input logic                dec_err
);

    assert_kind_shape_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc_kind) && !(dec_err && (acc_kind != '0 || region_idx != '0)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(acc_kind) && $stable(region_idx) && $stable(dec_err));

    assert_ram_first_R3: assert property (@(posedge clk) disable iff (rst)
        start && (hit[SLOT_RAM0] || hit[SLOT_RAM1]) |=> acc_kind == KIND_RAM && !dec_err);

    assert_bus2_next_R4: assert property (@(posedge clk) disable iff (rst)
        start && !hit[SLOT_RAM0] && !hit[SLOT_RAM1] && hit[SLOT_BUS2]
        |=> acc_kind == KIND_BUS2 && region_idx == IDX_W'(SLOT_BUS2));

    assert_single_cs_R6: assert property (@(posedge clk) disable iff (rst)
        start && hit[SLOT_BUS2:SLOT_RAM0] == '0 && $countones(hit[SLOT_CS1:SLOT_CS0]) == 1
        && hit[SLOT_DR1:SLOT_DR0] == '0 |=> acc_kind == KIND_CHIPSEL);

    assert_no_hit_R8: assert property (@(posedge clk) disable iff (rst)
        start && hit == '0 |=> dec_err);

endmodule

bind addr_region_decoder addr_region_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .hit        (hit),
    .acc_kind   (acc_kind),
    .region_idx (region_idx),
    .dec_err    (dec_err)
);

// File: tb/addr_region_decoder_tb.sv
module addr_region_decoder_tb;

    localparam logic [4:0] K0   = 5'b00000;
    localparam logic [4:0] KRAM = 5'b00001;
    localparam logic [4:0] KB2  = 5'b00010;
    localparam logic [4:0] KB1  = 5'b00100;
    localparam logic [4:0] KCS  = 5'b01000;
    localparam logic [4:0] KDR  = 5'b10000;

    typedef struct packed {
        logic [31:0] a;
        logic [4:0]  kind;
        logic [2:0]  idx;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{32'h2034_1234, KRAM, 3'd0, 1'b0, 4'd3},  // R3 RAM0 masked window
        '{32'h4000_0010, KRAM, 3'd1, 1'b0, 4'd3},  // R3 RAM1 beats BUS2
        '{32'h4000_FFFF, KRAM, 3'd1, 1'b0, 4'd1},  // R1 low bits ignored
        '{32'h4001_0000, KB2,  3'd3, 1'b0, 4'd4},  // R4
        '{32'h5000_0000, KB1,  3'd2, 1'b0, 4'd5},  // R5
        '{32'h5200_ABCD, KB1,  3'd2, 1'b0, 4'd5},  // R5 DRAM overlap allowed
        '{32'h5180_0000, K0,   3'd0, 1'b1, 4'd9},  // R9 BUS1 plus chip select
        '{32'h6042_0000, KCS,  3'd5, 1'b0, 4'd6},  // R6
        '{32'h7000_0004, KDR,  3'd6, 1'b0, 4'd7},  // R7
        '{32'h7FFF_FFFF, KDR,  3'd6, 1'b0, 4'd7},  // R7 upper mask edge
        '{32'h1000_0000, K0,   3'd0, 1'b1, 4'd8},  // R8
        '{32'h20FF_FFFF, KRAM, 3'd0, 1'b0, 4'd1},  // R1 mask edge inside
        '{32'h2100_0000, K0,   3'd0, 1'b1, 4'd1},  // R1 bit outside mask
        '{32'h5300_0000, KB1,  3'd2, 1'b0, 4'd13}  // R13 neighbour slots untouched
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_valid = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_mask = '0;
    logic        start = 1'b0;
    logic [31:0] addr = '0;
    logic [4:0]  acc_kind;
    logic [2:0]  region_idx;
    logic        dec_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    addr_region_decoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_valid  (cfg_valid),
        .cfg_base   (cfg_base),
        .cfg_mask   (cfg_mask),
        .start      (start),
        .addr       (addr),
        .acc_kind   (acc_kind),
        .region_idx (region_idx),
        .dec_err    (dec_err)
    );

    task automatic check(string req, logic [4:0] ek, logic [2:0] ei, logic ee);
        n_run++;
        if (acc_kind !== ek || region_idx !== ei || dec_err !== ee) begin
            n_fail++;
            $display("FAIL %s: kind=%b idx=%0d err=%b expected kind=%b idx=%0d err=%b",
                     req, acc_kind, region_idx, dec_err, ek, ei, ee);
        end
    endtask

    task automatic wr(logic [2:0] i, logic v, logic [15:0] b, logic [15:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_valid = v; cfg_base = b; cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic decode(logic [31:0] a);
        @(negedge clk);
        addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R12 reset outputs", K0, 3'd0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 idle after reset", K0, 3'd0, 1'b0);

        // all regions invalid after reset: nothing can hit (R2, R12)
        decode(32'h0000_0000);
        check("R2 invalid zero region", K0, 3'd0, 1'b1);

        // region map for the sweep (R13)
        wr(3'd0, 1'b1, 16'h2000, 16'h00FF);
        wr(3'd1, 1'b1, 16'h4000, 16'h0000);
        wr(3'd2, 1'b1, 16'h5000, 16'h0FFF);
        wr(3'd3, 1'b1, 16'h4000, 16'h0FFF);
        wr(3'd4, 1'b1, 16'h5100, 16'h00FF);
        wr(3'd5, 1'b1, 16'h6000, 16'h00FF);
        wr(3'd6, 1'b1, 16'h7000, 16'h0FFF);
        wr(3'd7, 1'b1, 16'h5200, 16'h00FF);

        for (int i = 0; i < NV; i++) begin
            decode(VEC[i].a);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].kind, VEC[i].idx, VEC[i].err);
        end

        // R11: hold while start low despite address and config changes
        decode(32'h6042_0000);
        addr = 32'h1000_0000;
        wr(3'd5, 1'b0, 16'h0000, 16'h0000);
        repeat (3) @(negedge clk);
        check("R11 hold without start", KCS, 3'd5, 1'b0);
        wr(3'd5, 1'b1, 16'h6000, 16'h00FF);

        // R9: chip select together with DRAM
        wr(3'd7, 1'b1, 16'h6000, 16'h00FF);
        decode(32'h6042_0000);
        check("R9 chip select with DRAM", K0, 3'd0, 1'b1);

        // R2: clearing the DRAM valid bit removes the overlap
        wr(3'd7, 1'b0, 16'h6000, 16'h00FF);
        decode(32'h6042_0000);
        check("R2 cleared valid bit", KCS, 3'd5, 1'b0);

        // R9: two chip selects
        wr(3'd4, 1'b1, 16'h6000, 16'h00FF);
        decode(32'h6042_0000);
        check("R9 two chip selects", K0, 3'd0, 1'b1);

        // R9 / R7: two DRAM regions, then only one
        wr(3'd7, 1'b1, 16'h7000, 16'h0000);
        decode(32'h7000_0000);
        check("R9 two DRAM regions", K0, 3'd0, 1'b1);
        decode(32'h7001_0000);
        check("R7 single DRAM", KDR, 3'd6, 1'b0);

        // R3: both RAM regions hit, lower index wins
        wr(3'd1, 1'b1, 16'h2000, 16'h00FF);
        decode(32'h2010_0000);
        check("R3 lowest RAM slot", KRAM, 3'd0, 1'b0);

        // R12: reset in mid-run clears outputs and configuration
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12 reset clears outputs", K0, 3'd0, 1'b0);
        rst = 1'b0;
        decode(32'h2010_0000);
        check("R12 reset clears regions", K0, 3'd0, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule